// File: doc/BRIEF.md
# Block Feedback Weight Updater

This block runs the digital side of a block-wise least-squares feedback loop around an external beamformer. It accepts input samples on a valid/ready strobe and counts them into blocks of `BLOCK_LEN` samples. When a block is complete, it stops taking samples and asks an attached least-squares solver to flush its weight-correction vector. It then receives `NUM_AUX` correction values, one per auxiliary channel, in channel order.

Each correction is scaled by a programmable gain and added to the matching stored weight, with saturation. After the last weight has been written, the block clears the solver and reports that the update is complete. The next block then starts. The updated weights drive the external beamformer. Because the solver's input is the beamformer's own residual, the correction removes the error that remains after the current weights are applied.

Top module: `block_fb_weights`

## Requirements
- R1: While reset is asserted, every weight reads zero and `smp_ready` and `solver_flush` are low. In the first cycle after reset is released, `solver_clear` is high and `smp_ready` is low. From the following cycle, `smp_ready` is high.
- R2: `smp_ready` stays high until `BLOCK_LEN` samples have been accepted. A sample is accepted when `smp_valid` and `smp_ready` are both high at a clock edge. In the cycle after the last accepted sample of a block, `smp_ready` is low and `solver_flush` is high for exactly one cycle.
- R3: The i-th correction accepted after a flush updates weight i, and only weight i. Weight i sits at bits [16i+15:16i] of `weights`. The new value is w + floor(g·Δ/128), where g is the gain in unsigned Q1.7 and Δ is the signed correction. The new value is visible in the cycle after the correction is accepted.
- R4: A `gain` value of 256 or more is used as 255, which is the largest Q1.7 code below 2.0.
- R5: A weight update that would leave the signed 16-bit range is clamped: to 32767 on the positive side and to -32768 on the negative side.
- R6: In the cycle after the last correction is accepted, `upd_done` and `solver_clear` are both high for one cycle and `smp_ready` is still low. All weights already hold their new values in that cycle. In the next cycle, `smp_ready` is high again.
- R7: `corr_valid` is ignored in every phase except correction collection. This includes the sample phase and the flush cycle. A correction presented in those phases changes no weight.
- R8: Cycles with `smp_valid` low are not counted toward the block. The block length counts accepted samples only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | An input sample is offered |
| smp_ready | output | 1 | Samples are being accepted |
| gain | input | 9 | Update gain, unsigned, 7 fraction bits |
| solver_clear | output | 1 | Returns the solver to its null state |
| solver_flush | output | 1 | Requests the correction vector from the solver |
| corr_valid | input | 1 | A correction value is present |
| corr_data | input | 16 | Signed correction value |
| weights | output | 16*NUM_AUX | Signed weights, weight i at bits [16i+15:16i] |
| upd_done | output | 1 | Pulses once when a block's weights have all been updated |

## Verification
The bench builds the block with `NUM_AUX=3` and `BLOCK_LEN=5`. With these small values, more than twenty complete blocks fit in a short run. Both the last-weight handoff to `upd_done` and the sample-count boundary are therefore hit many times. Random gaps in `smp_valid` and between corrections, together with stray corrections sent during the sample and flush phases, test whether the block counts and ignores inputs correctly. Directed blocks with full-scale corrections at gain 255 drive the weights against both 16-bit rails. A gain above 255 checks the gain clamp.

// File: rtl/block_fb_weights.sv
module block_fb_weights #(
  parameter int NUM_AUX   = 4,
  parameter int BLOCK_LEN = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [8:0]              gain,
  output logic                    solver_clear,
  output logic                    solver_flush,
  input  logic                    corr_valid,
  input  logic signed [15:0]      corr_data,
  output logic [16*NUM_AUX-1:0]   weights,
  output logic                    upd_done
);
  localparam int CW = $clog2(BLOCK_LEN + 1);
  localparam int IW = $clog2(NUM_AUX + 1);

  typedef enum logic [2:0] {S_INIT, S_RUN, S_REQ, S_COLLECT, S_DONE} state_t;
  state_t state;

  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic signed [15:0] w_q [NUM_AUX];
  logic signed [15:0] w_sel, w_new;
  logic [7:0] g_eff;
  logic signed [24:0] prod, delta;
  logic signed [17:0] sum;
  logic take, accept;

  assign smp_ready    = (state == S_RUN);
  assign solver_flush = (state == S_REQ);
  assign solver_clear = (state == S_INIT) || (state == S_DONE);
  assign upd_done     = (state == S_DONE);

  assign accept = smp_valid && smp_ready;
  assign take   = corr_valid && (state == S_COLLECT);
  assign g_eff  = gain[8] ? 8'hFF : gain[7:0];
  assign prod   = $signed({1'b0, g_eff}) * corr_data;
  assign delta  = prod >>> 7;
  assign sum    = $signed({{2{w_sel[15]}}, w_sel}) + $signed(delta[17:0]);
  assign w_new  = (sum > 18'sd32767)  ? 16'sh7FFF :
                  (sum < -18'sd32768) ? 16'sh8000 : sum[15:0];

  always_comb begin
    w_sel = '0;
    for (int i = 0; i < NUM_AUX; i++)
      if (idx == IW'(i)) w_sel = w_q[i];
  end

  generate
    for (genvar g = 0; g < NUM_AUX; g++) begin : g_out
      assign weights[16*g +: 16] = w_q[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_INIT;
      cnt   <= '0;
      idx   <= '0;
      for (int i = 0; i < NUM_AUX; i++) w_q[i] <= '0;
    end else begin
      case (state)
        S_INIT: state <= S_RUN;
        S_RUN: if (accept) begin
          if (cnt == CW'(BLOCK_LEN - 1)) begin
            cnt   <= '0;
            state <= S_REQ;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REQ: begin
          idx   <= '0;
          state <= S_COLLECT;
        end
        S_COLLECT: if (take) begin
          for (int i = 0; i < NUM_AUX; i++)
            if (idx == IW'(i)) w_q[i] <= w_new;
          if (idx == IW'(NUM_AUX - 1)) state <= S_DONE;
          else idx <= idx + 1'b1;
        end
        S_DONE: state <= S_RUN;
        default: state <= S_INIT;
      endcase
    end
  end
endmodule

// File: rtl/block_fb_weights_chk.sv
module block_fb_weights_chk #(
  parameter int NUM_AUX   = 4,
  parameter int BLOCK_LEN = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  smp_valid,
  input logic                  smp_ready,
  input logic                  solver_clear,
  input logic                  solver_flush,
  input logic                  corr_valid,
  input logic [16*NUM_AUX-1:0] weights,
  input logic                  upd_done
);
  int acc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= 0;
    else if (solver_flush) acc <= 0;
    else if (smp_valid && smp_ready) acc <= acc + 1;
  end

  p_flush_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    solver_flush |-> $past(smp_valid && smp_ready));
  p_no_ready_in_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    solver_flush |-> !smp_ready);
  p_block_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= BLOCK_LEN);
  p_flush_full_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    solver_flush |-> acc == BLOCK_LEN);
  p_done_with_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> solver_clear && !smp_ready);
  p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    solver_clear |=> smp_ready);
  p_weights_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(weights) |-> $past(corr_valid));
endmodule

bind block_fb_weights block_fb_weights_chk #(.NUM_AUX(NUM_AUX), .BLOCK_LEN(BLOCK_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .solver_clear(solver_clear), .solver_flush(solver_flush), .corr_valid(corr_valid),
  .weights(weights), .upd_done(upd_done)
);

// File: tb/sim_block_fb_weights.sv
module sim_block_fb_weights;
  localparam int NA = 3;
  localparam int KL = 5;

  logic clk = 0, rst_n = 0, smp_valid = 0, corr_valid = 0;
  logic [8:0] gain = 0;
  logic signed [15:0] corr_data = 0;
  logic smp_ready, solver_clear, solver_flush, upd_done;
  logic [16*NA-1:0] weights;

  int checks = 0, fails = 0;
  int model [NA];
  int cv [NA];
  bit fin = 0;

  block_fb_weights #(.NUM_AUX(NA), .BLOCK_LEN(KL)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .gain(gain), .solver_clear(solver_clear), .solver_flush(solver_flush),
    .corr_valid(corr_valid), .corr_data(corr_data), .weights(weights), .upd_done(upd_done));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wt(input int i);
    return int'($signed(weights[16*i +: 16]));
  endfunction

  function automatic int nxt(input int w, input int g, input int c);
    int ge, s;
    ge = (g > 255) ? 255 : g;
    s  = w + ((ge * c) >>> 7);
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic run_block(input int g, input bit rnd, input string tag);
    int acc;
    acc = 0;
    gain = g[8:0];
    while (acc < KL) begin
      @(negedge clk);
      chk(smp_ready == 1, "R2 R8 ready mid-block", int'(smp_ready), 1);
      smp_valid  = rnd ? 1'($urandom % 2) : 1'b1;
      corr_valid = rnd ? ($urandom % 4 == 0) : 1'b0;
      corr_data  = 16'($urandom);
      @(posedge clk);
      if (smp_valid) acc++;
    end
    @(negedge clk);
    smp_valid = 0;
    corr_valid = 1;
    corr_data = 16'sh7FFF;
    chk(solver_flush == 1, "R2 flush after block", int'(solver_flush), 1);
    chk(smp_ready == 0, "R2 ready low in flush", int'(smp_ready), 0);
    for (int i = 0; i < NA; i++) chk(wt(i) == model[i], "R7 run-phase corr ignored", wt(i), model[i]);
    @(negedge clk);
    corr_valid = 0;
    chk(solver_flush == 0, "R2 flush one cycle", int'(solver_flush), 0);
    for (int i = 0; i < NA; i++) chk(wt(i) == model[i], "R7 flush-cycle corr ignored", wt(i), model[i]);
    for (int i = 0; i < NA; i++) begin
      if (rnd) repeat ($urandom % 3) @(negedge clk);
      corr_valid = 1;
      corr_data = 16'(cv[i]);
      @(negedge clk);
      corr_valid = 0;
      model[i] = nxt(model[i], g, cv[i]);
      chk(wt(i) == model[i], tag, wt(i), model[i]);
      chk(smp_ready == 0, "R6 ready low during update", int'(smp_ready), 0);
      if (i < NA - 1) chk(upd_done == 0, "R6 no early done", int'(upd_done), 0);
      else chk(upd_done && solver_clear, "R6 done with clear", int'(upd_done), 1);
    end
    for (int i = 0; i < NA; i++) chk(wt(i) == model[i], "R3 all weights at done", wt(i), model[i]);
    @(negedge clk);
    chk(smp_ready == 1, "R6 ready resumes", int'(smp_ready), 1);
    chk(upd_done == 0, "R6 done one cycle", int'(upd_done), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!fin) begin
      fin = 1;
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NA; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NA; i++) chk(wt(i) == 0, "R1 reset weights", wt(i), 0);
    chk(smp_ready == 0, "R1 ready in reset", int'(smp_ready), 0);
    chk(solver_flush == 0, "R1 flush in reset", int'(solver_flush), 0);
    rst_n = 1;
    #1;
    chk(solver_clear == 1, "R1 clear after reset", int'(solver_clear), 1);
    chk(smp_ready == 0, "R1 ready during clear", int'(smp_ready), 0);
    @(negedge clk);
    chk(smp_ready == 1, "R1 ready after clear", int'(smp_ready), 1);
    chk(solver_clear == 0, "R1 clear one cycle", int'(solver_clear), 0);

    cv = '{100, -200, 300};     run_block(128, 0, "R3 unity gain");
    cv = '{3, -3, 1};           run_block(64, 0, "R3 half gain floor");
    cv = '{128, -128, 1000};    run_block(300, 0, "R4 gain clamp");
    cv = '{32767, -32768, 32767}; run_block(255, 0, "R5 saturation");
    cv = '{32767, -32768, 32767}; run_block(511, 0, "R5 saturation hold");
    cv = '{-32768, 32767, -32768}; run_block(255, 0, "R5 swing back");
    cv = '{-32768, 32767, -32768}; run_block(255, 0, "R5 opposite rails");
    for (int b = 0; b < 20; b++) begin
      for (int i = 0; i < NA; i++) cv[i] = int'($signed(16'($urandom)));
      run_block(int'($urandom % 512), 1, "R3 R8 random block");
    end

    fin = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule